// File: doc/BRIEF.md
# Interrupt-driven packet filter controller

This block sits next to an Ethernet controller and screens traffic in hardware. It services the controller's interrupts over a simple register-access bus, with one read or one write per cycle. When a transmit completes, it reads the sent frame's status word and Ethertype. It then takes the destination IP address from the frame and asks an external address table to learn it. When a frame arrives, it checks the status word and takes the source IP address. It looks that address up in the same table. A hit tells software that an accepted frame is waiting. A miss, a bad status or an unsupported Ethertype makes the block tell the controller to drop the frame. In that case it polls the controller until the drop has finished.

The block is an eight-state handler. Each state steps through its bus accesses with an inner step counter. Two shared subroutine states return to whichever state called them: a timed pre-fetch wait and an Ethertype decode. The timed wait stands in for a ready handshake, which the device bus does not have. Every handled interrupt first saves the controller's packet-number and pointer registers, and ends by writing them back.

Device register map (4-bit address): 0 interrupt status (read; bit0 receive, bit1 transmit-done, bit2 error), 1 interrupt acknowledge (write; same bit positions), 2 packet number, 3 buffer pointer (bit15 = 1 selects the receive buffer, bits 10:0 are the byte offset), 4 buffer data (16-bit word at the pointer; the pointer advances by 2 after each read), 5 completed-transmit packet number, 6 received packet number, 7 buffer manager (write 0x0080 = drop-and-free the current receive frame; read bit0 = busy).

Top module: `pf_irq_filter`

## Requirements
- R1: After reset, and whenever the block is idle, it makes no bus read or write and raises no learn, lookup or accept output. It never reads and writes in the same cycle.
- R2: Every handled interrupt starts by reading the packet-number register (address 2) and the pointer register (address 3). It ends by writing both saved values back, so their values after handling equal their values before.
- R3: Causes are taken in the order error, then transmit, then receive. An error cause is cleared by writing 0x0004 to address 1, with no access to frame data. A transmit cause that is still pending is handled afterwards, in a second pass.
- R4: Each read of buffer data (address 4) comes at least 13 cycles after the latest write to the pointer register.
- R5: On transmit-done, the block reads address 5 and writes the value to address 2. It then reads the status word at transmit-buffer offset 0; bit0 = 1 means success. On success with a supported Ethertype, it pulses lrn_req once, with the destination IP on lrn_key.
- R6: The Ethertype is the word at byte offset 12. 0x0800 (IPv4) selects offset 26 for a received frame and 30 for a sent frame. 0x0806 (ARP) selects offset 28 for a received frame and 38 for a sent frame. The 32-bit key is the word at that offset (upper half) followed by the next word.
- R7: A transmit with status bit0 = 0, or with any other Ethertype, gives no learn request. It is acknowledged with 0x0002 on address 1.
- R8: On receive, the block reads address 6 into address 2 and checks the status at receive-buffer offset 0. It pulses lkp_req with the source IP on lkp_key. If lkp_hit is high in the following cycle, pkt_accept pulses in that same cycle, and the interrupt is acknowledged with 0x0001, with no drop command.
- R9: A receive with a lookup miss, status bit0 = 0, or an unsupported Ethertype writes 0x0080 to address 7. The block then reads address 7 until bit0 is 0, and only then acknowledges with 0x0001. Bad-status and bad-Ethertype frames are not looked up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_irq | input | 1 | Level interrupt from the network controller |
| dev_addr | output | 4 | Device register address |
| dev_rd | output | 1 | Read strobe; dev_rdata is sampled in the same cycle |
| dev_wr | output | 1 | Write strobe |
| dev_wdata | output | 16 | Write data |
| dev_rdata | input | 16 | Read data |
| lrn_req | output | 1 | Learn request pulse |
| lrn_key | output | 32 | Destination IP to learn |
| lkp_req | output | 1 | Lookup request pulse |
| lkp_key | output | 32 | Source IP to look up |
| lkp_hit | input | 1 | Lookup result, valid the cycle after lkp_req |
| pkt_accept | output | 1 | Pulse: an accepted frame is waiting for software |

## Verification
The assertions take three things for granted about the inputs. The controller returns read data combinationally in the cycle of the read. It presents the lookup result exactly one cycle after the request. Its busy flag clears within a bounded number of polls. The bench's register-and-buffer model has all three properties: it answers reads combinationally, registers lkp_hit from lkp_req, and counts busy down once per status poll. Its interrupt lines stay set until an acknowledge write clears them, so every interrupt pass ends with the lines idle.

// File: rtl/pf_pkg.sv
package pf_pkg;

  localparam int AW    = 4;
  localparam int OFF_W = 11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAUSE,
    ST_RX,
    ST_TX,
    ST_RESTORE,
    ST_RELEASE,
    ST_PREF,
    ST_ETYPE
  } pf_state_e;

  localparam logic [AW-1:0] REG_IST    = 4'd0;
  localparam logic [AW-1:0] REG_ACK    = 4'd1;
  localparam logic [AW-1:0] REG_PNR    = 4'd2;
  localparam logic [AW-1:0] REG_PTR    = 4'd3;
  localparam logic [AW-1:0] REG_DATA   = 4'd4;
  localparam logic [AW-1:0] REG_TXDONE = 4'd5;
  localparam logic [AW-1:0] REG_RXNUM  = 4'd6;
  localparam logic [AW-1:0] REG_MMU    = 4'd7;

  localparam int BIT_RX  = 0;
  localparam int BIT_TX  = 1;
  localparam int BIT_ERR = 2;

  localparam logic [15:0] CMD_DROP  = 16'h0080;
  localparam logic [15:0] ETH_IPV4  = 16'h0800;
  localparam logic [15:0] ETH_ARP   = 16'h0806;

  localparam logic [OFF_W-1:0] OFF_STATUS   = 11'd0;
  localparam logic [OFF_W-1:0] OFF_ETYPE    = 11'd12;
  localparam logic [OFF_W-1:0] OFF_IP4_SRC  = 11'd26;
  localparam logic [OFF_W-1:0] OFF_IP4_DST  = 11'd30;
  localparam logic [OFF_W-1:0] OFF_ARP_SNDR = 11'd28;
  localparam logic [OFF_W-1:0] OFF_ARP_TGT  = 11'd38;

endpackage

// File: rtl/pf_offset_sel.sv
module pf_offset_sel
  import pf_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0]    etype,
  input  logic             is_rx,
  output logic [OFF_W-1:0] ip_off,
  output logic             known
);

  always_comb begin
    known  = 1'b1;
    ip_off = '0;
    if (etype == DW'(ETH_IPV4)) begin
      ip_off = is_rx ? OFF_IP4_SRC : OFF_IP4_DST;
    end else if (etype == DW'(ETH_ARP)) begin
      ip_off = is_rx ? OFF_ARP_SNDR : OFF_ARP_TGT;
    end else begin
      known = 1'b0;
    end
  end

endmodule

// File: rtl/pf_wait_timer.sv
module pf_wait_timer #(
  parameter int WAIT_CYCLES = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);

  localparam int CW = $clog2(WAIT_CYCLES + 1) + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign done = run && (cnt_q == CW'(WAIT_CYCLES));

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (!done) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(WAIT_CYCLES)); // R4

endmodule

// File: rtl/pf_ctx_store.sv
module pf_ctx_store #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          save_pnr,
  input  logic          save_ptr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] pnr_q,
  output logic [DW-1:0] ptr_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pnr_q <= '0;
    end else if (save_pnr) begin
      pnr_q <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (save_ptr) begin
      ptr_q <= din;
    end
  end

endmodule

// File: rtl/pf_irq_filter.sv
module pf_irq_filter
  import pf_pkg::*;
#(
  parameter int DW          = 16,
  parameter int WAIT_CYCLES = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dev_irq,
  output logic [AW-1:0]   dev_addr,
  output logic            dev_rd,
  output logic            dev_wr,
  output logic [DW-1:0]   dev_wdata,
  input  logic [DW-1:0]   dev_rdata,
  output logic            lrn_req,
  output logic [2*DW-1:0] lrn_key,
  output logic            lkp_req,
  output logic [2*DW-1:0] lkp_key,
  input  logic            lkp_hit,
  output logic            pkt_accept
);

  localparam int STEP_W = 4;
  localparam int GAP_W  = $clog2(WAIT_CYCLES + 2) + 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_i = rst_sync_q[1];

  pf_state_e         state, nxt_state, ret_state, nxt_ret;
  logic [STEP_W-1:0] step, nxt_step;
  logic [DW-1:0]     pnum_q, ip_hi_q, ip_lo_q;
  logic [2:0]        cause_q;
  logic              stat_ok_q;
  logic [OFF_W-1:0]  off_q, off_d;
  logic              off_ok_q, off_ok_d;
  logic              wait_done;
  logic              cap_cause, cap_pnum, cap_stat, cap_hi, cap_lo, cap_off;
  logic              save_pnr, save_ptr;
  logic [DW-1:0]     saved_pnr, saved_ptr;

  function automatic logic [DW-1:0] ptr_word(input logic rx, input logic [OFF_W-1:0] off);
    logic [DW-1:0] w;
    w            = '0;
    w[DW-1]      = rx;
    w[OFF_W-1:0] = off;
    return w;
  endfunction

  pf_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_wait (
    .clk  (clk),
    .rst_n(rst_i),
    .run  (state == ST_PREF),
    .done (wait_done)
  );

  pf_offset_sel #(.DW(DW)) u_off (
    .etype (dev_rdata),
    .is_rx (ret_state == ST_RX),
    .ip_off(off_d),
    .known (off_ok_d)
  );

  pf_ctx_store #(.DW(DW)) u_ctx (
    .clk     (clk),
    .rst_n   (rst_i),
    .save_pnr(save_pnr),
    .save_ptr(save_ptr),
    .din     (dev_rdata),
    .pnr_q   (saved_pnr),
    .ptr_q   (saved_ptr)
  );

  assign lrn_key = {ip_hi_q, ip_lo_q};
  assign lkp_key = {ip_hi_q, ip_lo_q};

  // next state and bus decode
  always_comb begin
    nxt_state  = state;
    nxt_step   = step;
    nxt_ret    = ret_state;
    dev_addr   = '0;
    dev_rd     = 1'b0;
    dev_wr     = 1'b0;
    dev_wdata  = '0;
    lrn_req    = 1'b0;
    lkp_req    = 1'b0;
    pkt_accept = 1'b0;
    cap_cause  = 1'b0;
    cap_pnum   = 1'b0;
    cap_stat   = 1'b0;
    cap_hi     = 1'b0;
    cap_lo     = 1'b0;
    cap_off    = 1'b0;
    save_pnr   = 1'b0;
    save_ptr   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (dev_irq) begin
          nxt_state = ST_CAUSE;
          nxt_step  = '0;
        end
      end
      ST_CAUSE: begin
        case (step)
          4'd0: begin
            dev_rd = 1'b1; dev_addr = REG_PNR; save_pnr = 1'b1; nxt_step = 4'd1;
          end
          4'd1: begin
            dev_rd = 1'b1; dev_addr = REG_PTR; save_ptr = 1'b1; nxt_step = 4'd2;
          end
          4'd2: begin
            dev_rd = 1'b1; dev_addr = REG_IST; cap_cause = 1'b1; nxt_step = 4'd3;
          end
          default: begin
            nxt_step = '0;
            if (cause_q[BIT_ERR]) begin
              dev_wr = 1'b1; dev_addr = REG_ACK; dev_wdata = DW'(1 << BIT_ERR);
              nxt_state = ST_RESTORE;
            end else if (cause_q[BIT_TX]) begin
              nxt_state = ST_TX;
            end else if (cause_q[BIT_RX]) begin
              nxt_state = ST_RX;
            end else begin
              nxt_state = ST_RESTORE;
            end
          end
        endcase
      end
      ST_TX, ST_RX: begin
        case (step)
          4'd0: begin
            dev_rd = 1'b1; cap_pnum = 1'b1; nxt_step = 4'd1;
            dev_addr = (state == ST_RX) ? REG_RXNUM : REG_TXDONE;
          end
          4'd1: begin
            dev_wr = 1'b1; dev_addr = REG_PNR; dev_wdata = pnum_q; nxt_step = 4'd2;
          end
          4'd2: begin
            dev_wr = 1'b1; dev_addr = REG_PTR;
            dev_wdata = ptr_word(state == ST_RX, OFF_STATUS);
            nxt_state = ST_PREF; nxt_ret = state; nxt_step = 4'd3;
          end
          4'd3: begin
            dev_rd = 1'b1; dev_addr = REG_DATA; cap_stat = 1'b1; nxt_step = 4'd4;
          end
          4'd4: begin
            if (!stat_ok_q) begin
              if (state == ST_RX) begin
                nxt_state = ST_RELEASE; nxt_step = '0;
              end else begin
                nxt_step = 4'd10;
              end
            end else begin
              dev_wr = 1'b1; dev_addr = REG_PTR;
              dev_wdata = ptr_word(state == ST_RX, OFF_ETYPE);
              nxt_state = ST_PREF; nxt_ret = state; nxt_step = 4'd5;
            end
          end
          4'd5: begin
            nxt_state = ST_ETYPE; nxt_ret = state; nxt_step = 4'd6;
          end
          4'd6: begin
            if (!off_ok_q) begin
              if (state == ST_RX) begin
                nxt_state = ST_RELEASE; nxt_step = '0;
              end else begin
                nxt_step = 4'd10;
              end
            end else begin
              dev_wr = 1'b1; dev_addr = REG_PTR;
              dev_wdata = ptr_word(state == ST_RX, off_q);
              nxt_state = ST_PREF; nxt_ret = state; nxt_step = 4'd7;
            end
          end
          4'd7: begin
            dev_rd = 1'b1; dev_addr = REG_DATA; cap_hi = 1'b1; nxt_step = 4'd8;
          end
          4'd8: begin
            dev_rd = 1'b1; dev_addr = REG_DATA; cap_lo = 1'b1; nxt_step = 4'd9;
          end
          4'd9: begin
            if (state == ST_RX) begin
              lkp_req = 1'b1;
            end else begin
              lrn_req = 1'b1;
            end
            nxt_step = 4'd10;
          end
          default: begin
            if (state == ST_RX && !lkp_hit) begin
              nxt_state = ST_RELEASE; nxt_step = '0;
            end else begin
              pkt_accept = (state == ST_RX);
              dev_wr = 1'b1; dev_addr = REG_ACK;
              dev_wdata = (state == ST_RX) ? DW'(1 << BIT_RX) : DW'(1 << BIT_TX);
              nxt_state = ST_RESTORE; nxt_step = '0;
            end
          end
        endcase
      end
      ST_RELEASE: begin
        case (step)
          4'd0: begin
            dev_wr = 1'b1; dev_addr = REG_MMU; dev_wdata = DW'(CMD_DROP); nxt_step = 4'd1;
          end
          4'd1: begin
            dev_rd = 1'b1; dev_addr = REG_MMU;
            if (!dev_rdata[0]) nxt_step = 4'd2;
          end
          default: begin
            dev_wr = 1'b1; dev_addr = REG_ACK; dev_wdata = DW'(1 << BIT_RX);
            nxt_state = ST_RESTORE; nxt_step = '0;
          end
        endcase
      end
      ST_RESTORE: begin
        dev_wr = 1'b1;
        if (step == 4'd0) begin
          dev_addr = REG_PNR; dev_wdata = saved_pnr; nxt_step = 4'd1;
        end else begin
          dev_addr = REG_PTR; dev_wdata = saved_ptr;
          nxt_state = ST_IDLE; nxt_step = '0;
        end
      end
      ST_PREF: begin
        if (wait_done) nxt_state = ret_state;
      end
      ST_ETYPE: begin
        dev_rd = 1'b1; dev_addr = REG_DATA; cap_off = 1'b1;
        nxt_state = ret_state;
      end
      default: begin
        nxt_state = ST_IDLE; nxt_step = '0;
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state     <= ST_IDLE;
      ret_state <= ST_IDLE;
      step      <= '0;
    end else begin
      state     <= nxt_state;
      ret_state <= nxt_ret;
      step      <= nxt_step;
    end
  end

  // captured read data, each with its own enable
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      cause_q   <= '0;
      pnum_q    <= '0;
      stat_ok_q <= 1'b0;
      ip_hi_q   <= '0;
      ip_lo_q   <= '0;
      off_q     <= '0;
      off_ok_q  <= 1'b0;
    end else begin
      if (cap_cause) cause_q   <= dev_rdata[2:0];
      if (cap_pnum)  pnum_q    <= dev_rdata;
      if (cap_stat)  stat_ok_q <= dev_rdata[0];
      if (cap_hi)    ip_hi_q   <= dev_rdata;
      if (cap_lo)    ip_lo_q   <= dev_rdata;
      if (cap_off) begin
        off_q    <= off_d;
        off_ok_q <= off_ok_d;
      end
    end
  end

  // cycles since the last pointer write, for the pre-fetch check
  logic [GAP_W-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      gap_q <= '0;
    end else if (dev_wr && dev_addr == REG_PTR) begin
      gap_q <= '0;
    end else if (gap_q != {GAP_W{1'b1}}) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  AST_NO_DUAL_ACCESS: assert property (@(posedge clk) disable iff (!rst_i)
    !(dev_rd && dev_wr)); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_i)
    (state == ST_IDLE) |-> !(dev_rd || dev_wr || lrn_req || lkp_req || pkt_accept)); // R1

  AST_PREFETCH_GAP: assert property (@(posedge clk) disable iff (!rst_i)
    (dev_rd && dev_addr == REG_DATA) |-> (gap_q >= GAP_W'(WAIT_CYCLES + 1))); // R4

  AST_SUB_RETURN: assert property (@(posedge clk) disable iff (!rst_i)
    (state == ST_PREF && wait_done) |=> (state == $past(ret_state))); // R4

  AST_ACCEPT_AFTER_LOOKUP: assert property (@(posedge clk) disable iff (!rst_i)
    pkt_accept |-> ($past(lkp_req) && lkp_hit)); // R8

  AST_DROP_THEN_POLL: assert property (@(posedge clk) disable iff (!rst_i)
    (dev_wr && dev_addr == REG_MMU) |=> (dev_rd && dev_addr == REG_MMU)); // R9

endmodule

// File: tb/pf_irq_filter_test.sv
module pf_irq_filter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  dev_addr;
  logic        dev_rd, dev_wr;
  logic [15:0] dev_wdata, dev_rdata;
  logic        lrn_req, lkp_req, pkt_accept;
  logic [31:0] lrn_key, lkp_key;
  logic        lkp_hit = 1'b0;
  logic        dev_irq;

  always #4 clk = ~clk;

  pf_irq_filter uut (
    .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq),
    .dev_addr(dev_addr), .dev_rd(dev_rd), .dev_wr(dev_wr),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
    .lrn_req(lrn_req), .lrn_key(lrn_key),
    .lkp_req(lkp_req), .lkp_key(lkp_key),
    .lkp_hit(lkp_hit), .pkt_accept(pkt_accept)
  );

  // controller model
  logic [15:0] tx_mem [0:31];
  logic [15:0] rx_mem [0:31];
  logic [2:0]  m_ist = 3'b0;
  logic [15:0] m_pnr = 16'h0, m_ptr = 16'h0;
  logic [7:0]  busy_left = 8'd0;
  logic        load = 1'b0;
  logic [2:0]  cfg_ist = 3'b0;
  logic [15:0] cfg_pnr = 16'h0, cfg_ptr = 16'h0;
  logic [7:0]  cfg_busy = 8'd0;
  logic        cfg_hit = 1'b0;
  localparam logic [15:0] TXDONE_NUM = 16'h0003;
  localparam logic [15:0] RXNUM_NUM  = 16'h0009;

  int cyc = 0, last_ptr = -100;
  int ack_cnt = 0, ack_busy = 0, rel_cnt = 0, bad_acc = 0, early = 0, data_rd = 0;
  int lrn_cnt = 0, lkp_cnt = 0, acc_cnt = 0;
  logic [15:0] last_ack = 16'h0;
  logic [31:0] lrn_last = 32'h0, lkp_last = 32'h0;
  int vectors = 0, fails = 0;

  assign dev_irq = |m_ist;

  always_comb begin
    dev_rdata = 16'h0;
    case (dev_addr)
      4'd0: dev_rdata = {13'b0, m_ist};
      4'd2: dev_rdata = m_pnr;
      4'd3: dev_rdata = m_ptr;
      4'd4: dev_rdata = m_ptr[15] ? rx_mem[m_ptr[5:1]] : tx_mem[m_ptr[5:1]];
      4'd5: dev_rdata = TXDONE_NUM;
      4'd6: dev_rdata = RXNUM_NUM;
      4'd7: dev_rdata = {15'b0, busy_left != 8'd0};
      default: dev_rdata = 16'h0;
    endcase
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (load) begin
      m_ist <= cfg_ist; m_pnr <= cfg_pnr; m_ptr <= cfg_ptr; busy_left <= 8'd0;
    end
    if (dev_rd && dev_wr) bad_acc = bad_acc + 1;
    if (dev_wr) begin
      case (dev_addr)
        4'd1: begin
          ack_cnt = ack_cnt + 1; last_ack = dev_wdata;
          if (dev_wdata[0] && busy_left != 8'd0) ack_busy = ack_busy + 1;
          m_ist <= m_ist & ~dev_wdata[2:0];
        end
        4'd2: m_pnr <= dev_wdata;
        4'd3: begin m_ptr <= dev_wdata; last_ptr = cyc; end
        4'd7: if (dev_wdata == 16'h0080) begin
          rel_cnt = rel_cnt + 1; busy_left <= cfg_busy;
        end
        default: bad_acc = bad_acc + 1;
      endcase
    end
    if (dev_rd) begin
      if (dev_addr == 4'd4) begin
        data_rd = data_rd + 1;
        if (cyc - last_ptr < 13) early = early + 1;
        m_ptr <= m_ptr + 16'd2;
      end
      if (dev_addr == 4'd7 && busy_left != 8'd0) busy_left <= busy_left - 8'd1;
      if (dev_addr == 4'd1) bad_acc = bad_acc + 1;
    end
    if (lrn_req) begin lrn_cnt = lrn_cnt + 1; lrn_last = lrn_key; end
    if (lkp_req) begin lkp_cnt = lkp_cnt + 1; lkp_last = lkp_key; end
    if (pkt_accept) acc_cnt = acc_cnt + 1;
    lkp_hit <= lkp_req && cfg_hit;
  end

  function automatic logic [15:0] pat(input bit rx, input int w);
    return (rx ? 16'hB000 : 16'hA000) | 16'(w << 8) | 16'(w);
  endfunction

  function automatic logic [31:0] ip_at(input bit rx, input int off);
    return {pat(rx, off / 2), pat(rx, off / 2 + 1)};
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    vectors = vectors + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one interrupt scenario; expected values come from the requirements
  task automatic run_case(input string nm, input logic [2:0] ist, input bit ok,
                          input logic [15:0] et, input bit hit, input logic [7:0] busy,
                          input int e_lrn, input int e_lkp, input int e_acc, input int e_rel,
                          input int e_acks, input logic [15:0] e_last, input logic [31:0] e_key);
    int s_ack, s_rel, s_lrn, s_lkp, s_acc, s_early, s_busy, s_data, s_bad;
    for (int w = 0; w < 32; w++) begin
      tx_mem[w] = pat(1'b0, w);
      rx_mem[w] = pat(1'b1, w);
    end
    tx_mem[0] = {15'b0, ok}; rx_mem[0] = {15'b0, ok};
    tx_mem[6] = et;          rx_mem[6] = et;
    cfg_ist = ist; cfg_hit = hit; cfg_busy = busy;
    cfg_pnr = 16'h0005 + 16'(vectors); cfg_ptr = 16'h1234 + 16'(vectors);
    s_ack = ack_cnt; s_rel = rel_cnt; s_lrn = lrn_cnt; s_lkp = lkp_cnt; s_acc = acc_cnt;
    s_early = early; s_busy = ack_busy; s_data = data_rd; s_bad = bad_acc;
    @(negedge clk) load = 1'b1;
    @(negedge clk) load = 1'b0;
    repeat (300) @(negedge clk);
    chk({nm, " R5 R7 learn count"}, lrn_cnt - s_lrn, e_lrn);
    if (e_lrn != 0) chk({nm, " R6 learn key"}, lrn_last, e_key);
    chk({nm, " R8 R9 lookup count"}, lkp_cnt - s_lkp, e_lkp);
    if (e_lkp != 0) chk({nm, " R6 lookup key"}, lkp_last, e_key);
    chk({nm, " R8 accept count"}, acc_cnt - s_acc, e_acc);
    chk({nm, " R9 drop count"}, rel_cnt - s_rel, e_rel);
    chk({nm, " R9 ack while busy"}, ack_busy - s_busy, 0);
    chk({nm, " R3 ack count"}, ack_cnt - s_ack, e_acks);
    chk({nm, " R3 last ack"}, last_ack, e_last);
    chk({nm, " R3 irq cleared"}, m_ist, 0);
    chk({nm, " R2 pnr restored"}, m_pnr, cfg_pnr);
    chk({nm, " R2 ptr restored"}, m_ptr, cfg_ptr);
    chk({nm, " R4 early data reads"}, early - s_early, 0);
    chk({nm, " R1 illegal access"}, bad_acc - s_bad, 0);
    if (ist == 3'b100) chk({nm, " R3 no data access"}, data_rd - s_data, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset rd", dev_rd, 0);
    chk("R1 reset wr", dev_wr, 0);
    chk("R1 reset lrn/lkp/acc", {lrn_req, lkp_req, pkt_accept}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 idle quiet", {dev_rd, dev_wr, lrn_req, lkp_req, pkt_accept}, 0);

    run_case("tx ipv4",    3'b010, 1'b1, 16'h0800, 1'b0, 8'd0, 1, 0, 0, 0, 1, 16'h0002, ip_at(1'b0, 30));
    run_case("tx arp",     3'b010, 1'b1, 16'h0806, 1'b0, 8'd0, 1, 0, 0, 0, 1, 16'h0002, ip_at(1'b0, 38));
    run_case("tx bad st",  3'b010, 1'b0, 16'h0800, 1'b0, 8'd0, 0, 0, 0, 0, 1, 16'h0002, 32'h0);
    run_case("tx bad et",  3'b010, 1'b1, 16'h86DD, 1'b0, 8'd0, 0, 0, 0, 0, 1, 16'h0002, 32'h0);
    run_case("rx ipv4 hit",3'b001, 1'b1, 16'h0800, 1'b1, 8'd0, 0, 1, 1, 0, 1, 16'h0001, ip_at(1'b1, 26));
    run_case("rx arp hit", 3'b001, 1'b1, 16'h0806, 1'b1, 8'd0, 0, 1, 1, 0, 1, 16'h0001, ip_at(1'b1, 28));
    run_case("rx arp miss",3'b001, 1'b1, 16'h0806, 1'b0, 8'd4, 0, 1, 0, 1, 1, 16'h0001, ip_at(1'b1, 28));
    run_case("rx ip miss", 3'b001, 1'b1, 16'h0800, 1'b0, 8'd0, 0, 1, 0, 1, 1, 16'h0001, ip_at(1'b1, 26));
    run_case("rx bad st",  3'b001, 1'b0, 16'h0800, 1'b1, 8'd2, 0, 0, 0, 1, 1, 16'h0001, 32'h0);
    run_case("rx bad et",  3'b001, 1'b1, 16'h1234, 1'b1, 8'd1, 0, 0, 0, 1, 1, 16'h0001, 32'h0);
    run_case("err only",   3'b100, 1'b1, 16'h0800, 1'b0, 8'd0, 0, 0, 0, 0, 1, 16'h0004, 32'h0);
    run_case("err+tx",     3'b110, 1'b1, 16'h0800, 1'b0, 8'd0, 1, 0, 0, 0, 2, 16'h0002, ip_at(1'b0, 30));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails = fails + 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule